// File: doc/BRIEF.md
# Transmit Byte FIFO with Entry-Slot and Drained Triggers

This block sits between a byte-wide write port, fed by a processor or a DMA engine, and the shift register of a serial transmitter. It holds up to four bytes in a short chain of stages. A byte written into the entry stage moves one stage per clock toward the exit stage, as long as the stage ahead is free or is being emptied in the same cycle. The shifter sees the exit stage as a valid byte and takes it by raising a read request.

The block raises two kinds of empty condition. The first is the entry stage being empty, which means there is room for the next write. The second is the whole chain being drained. The buffer-empty status bit always follows the entry stage. The interrupt and the DMA request each have their own select input, so either one can fire on room for one more byte or on the chain being fully drained. A write that arrives when no stage can make room is dropped, and it sets an overflow flag that stays set until reset.

Top module: `tx_fifo_dualempty`

## Requirements
- R1: After synchronous reset, every stage is empty: `tx_valid`=0, `buf_empty`=1, `overflow`=0, and `irq` is 1 with either select value.
- R2: Bytes leave at the exit stage in the order they were written, and up to four bytes are held at once.
- R3: A write while all four stages are full and no read is requested is dropped. The stored bytes do not change, and `overflow` goes to 1 and stays 1 until reset.
- R4: `buf_empty` is 0 in the cycle after a write is accepted. It returns to 1 once that byte has moved on from the entry stage and no new write has refilled it.
- R5: A byte written alone into an empty chain advances one stage per clock. `tx_valid` rises after the third clock edge that follows the write edge.
- R6: `irq_sel`=0 makes `irq` follow entry-stage-empty. `irq_sel`=1 makes `irq` follow all-stages-empty.
- R7: `dma_sel` chooses between the same two conditions for `dma_req` (0 = entry stage empty, 1 = all empty). In the cycle where a write is being accepted, `dma_req` is 0.
- R8: The exit byte stays valid and stable until `tx_take` is raised. A take in a cycle removes exactly that byte.
- R9: When the chain is full, a write together with a take in the same cycle is accepted: the chain shifts and the new byte enters without setting `overflow`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe for the entry stage |
| wr_byte | input | 8 | Byte to write |
| tx_take | input | 1 | Shifter takes the exit byte |
| tx_valid | output | 1 | Exit stage holds a byte |
| tx_byte | output | 8 | Exit stage byte |
| irq_sel | input | 1 | Interrupt trigger: 0 entry empty, 1 all empty |
| dma_sel | input | 1 | DMA trigger: 0 entry empty, 1 all empty |
| buf_empty | output | 1 | Entry stage is empty |
| irq | output | 1 | Interrupt condition |
| dma_req | output | 1 | DMA request |
| overflow | output | 1 | Sticky dropped-write flag |

## Verification
A single byte written into an empty chain shows the per-stage latency and when the status bit clears and sets again. Four back-to-back writes followed by an extra write confirm that the order is kept and that the fifth byte is dropped rather than overwriting a stored one. A write and a take in the same cycle on a full chain separate "full" from "entry occupied". The trigger test switches both selects while the chain is partly filled, so that the entry-empty and all-empty choices give different levels on `irq` and `dma_req`.

// File: rtl/tfifo_pkg.sv
package tfifo_pkg;

    localparam int TF_DATA_W = 8;

    typedef logic [TF_DATA_W-1:0] byte_t;

    typedef enum logic {
        TRIG_ENTRY_EMPTY = 1'b0,
        TRIG_ALL_EMPTY   = 1'b1
    } trig_e;

    typedef struct packed {
        logic  vld;
        byte_t dat;
    } slot_t;

    function automatic logic pick_trigger(trig_e sel, logic entry_empty, logic all_empty);
        return (sel == TRIG_ALL_EMPTY) ? all_empty : entry_empty;
    endfunction

endpackage

// File: rtl/tfifo_stage.sv
module tfifo_stage
    import tfifo_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  byte_t in_dat,
    input  logic  leave,
    output slot_t slot
);

    always_ff @(posedge clk) begin
        if (rst) begin
            slot <= '0;
        end else begin
            slot.vld <= load | (slot.vld & ~leave);
            if (load) begin
                slot.dat <= in_dat;
            end
        end
    end

    // An occupied stage that is not handing on keeps its byte (R2)
    assert_stage_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (slot.vld && !leave) |=> (slot.vld && $stable(slot.dat)));

endmodule

// File: rtl/tfifo_flow.sv
module tfifo_flow #(
    parameter int DEPTH = 4
) (
    input  logic [DEPTH-1:0] vld,
    input  logic             take,
    input  logic             wr_en,
    output logic [DEPTH-1:0] mv,
    output logic             wr_acc
);

    always_comb begin
        mv[DEPTH-1] = vld[DEPTH-1] & take;
        for (int i = DEPTH - 2; i >= 0; i--) begin
            mv[i] = vld[i] & (~vld[i+1] | mv[i+1]);
        end
        wr_acc = wr_en & (~vld[0] | mv[0]);
    end

endmodule

// File: rtl/tfifo_events.sv
module tfifo_events
    import tfifo_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DEPTH-1:0] vld,
    input  logic             wr_en,
    input  logic             wr_acc,
    input  trig_e            irq_trig,
    input  trig_e            dma_trig,
    output logic             buf_empty,
    output logic             irq,
    output logic             dma_req,
    output logic             overflow
);

    logic entry_empty;
    logic all_empty;

    assign entry_empty = ~vld[0];
    assign all_empty   = ~|vld;
    assign buf_empty   = entry_empty;
    assign irq         = pick_trigger(irq_trig, entry_empty, all_empty);
    assign dma_req     = pick_trigger(dma_trig, entry_empty, all_empty) & ~wr_acc;

    always_ff @(posedge clk) begin
        if (rst) begin
            overflow <= 1'b0;
        end else if (wr_en && !wr_acc) begin
            overflow <= 1'b1;
        end
    end

    assert_accept_fills_entry_R4: assert property (@(posedge clk) disable iff (rst)
        wr_acc |=> !buf_empty);

    assert_drop_flags_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_acc) |=> overflow);

    assert_overflow_sticky_R3: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow);

endmodule

// File: rtl/tx_fifo_dualempty.sv
module tx_fifo_dualempty
    import tfifo_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] wr_byte,
    input  logic       tx_take,
    output logic       tx_valid,
    output logic [7:0] tx_byte,
    input  logic       irq_sel,
    input  logic       dma_sel,
    output logic       buf_empty,
    output logic       irq,
    output logic       dma_req,
    output logic       overflow
);

    localparam int LAST = DEPTH - 1;

    slot_t            slots [DEPTH];
    logic [DEPTH-1:0] vld;
    logic [DEPTH-1:0] mv;
    logic             wr_acc;

    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
        assign vld[g] = slots[g].vld;
        if (g == 0) begin : g_entry
            tfifo_stage u_stage (
                .clk    (clk),
                .rst    (rst),
                .load   (wr_acc),
                .in_dat (wr_byte),
                .leave  (mv[g]),
                .slot   (slots[g])
            );
        end else begin : g_inner
            tfifo_stage u_stage (
                .clk    (clk),
                .rst    (rst),
                .load   (mv[g-1]),
                .in_dat (slots[g-1].dat),
                .leave  (mv[g]),
                .slot   (slots[g])
            );
        end
    end

    tfifo_flow #(.DEPTH(DEPTH)) u_flow (
        .vld    (vld),
        .take   (tx_take),
        .wr_en  (wr_en),
        .mv     (mv),
        .wr_acc (wr_acc)
    );

    tfifo_events #(.DEPTH(DEPTH)) u_events (
        .clk       (clk),
        .rst       (rst),
        .vld       (vld),
        .wr_en     (wr_en),
        .wr_acc    (wr_acc),
        .irq_trig  (trig_e'(irq_sel)),
        .dma_trig  (trig_e'(dma_sel)),
        .buf_empty (buf_empty),
        .irq       (irq),
        .dma_req   (dma_req),
        .overflow  (overflow)
    );

    assign tx_valid = slots[LAST].vld;
    assign tx_byte  = slots[LAST].dat;

    assert_exit_stable_R8: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_take) |=> (tx_valid && $stable(tx_byte)));

    assert_dma_drop_on_write_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && buf_empty) |-> !dma_req);

    assert_irq_all_mode_R6: assert property (@(posedge clk) disable iff (rst)
        (irq_sel && tx_valid) |-> !irq);

    assert_occupancy_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_acc && !(tx_take && tx_valid)) |=> ($countones(vld) == $past($countones(vld)) + 1));

endmodule

// File: tb/tx_fifo_dualempty_tb_top.sv
module tx_fifo_dualempty_tb_top;

    logic       clk = 1'b0;
    logic       rst;
    logic       wr_en;
    logic [7:0] wr_byte;
    logic       tx_take;
    logic       tx_valid;
    logic [7:0] tx_byte;
    logic       irq_sel;
    logic       dma_sel;
    logic       buf_empty;
    logic       irq;
    logic       dma_req;
    logic       overflow;

    int n_checks = 0;
    int n_errors = 0;

    always #4 clk = ~clk;

    tx_fifo_dualempty dut_i (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_byte   (wr_byte),
        .tx_take   (tx_take),
        .tx_valid  (tx_valid),
        .tx_byte   (tx_byte),
        .irq_sel   (irq_sel),
        .dma_sel   (dma_sel),
        .buf_empty (buf_empty),
        .irq       (irq),
        .dma_req   (dma_req),
        .overflow  (overflow)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // one clock: rising edge, then back to the falling edge
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; wr_en = 1'b0; wr_byte = '0; tx_take = 1'b0;
        irq_sel = 1'b0; dma_sel = 1'b0;
        step();
        step();
        rst = 1'b0;
    endtask

    task automatic write_one(input logic [7:0] b);
        wr_en = 1'b1; wr_byte = b;
        step();
        wr_en = 1'b0;
    endtask

    task automatic t_reset_state();
        do_reset();
        chk("R1", "tx_valid", tx_valid, 0);
        chk("R1", "buf_empty", buf_empty, 1);
        chk("R1", "overflow", overflow, 0);
        chk("R1", "irq entry mode", irq, 1);
        irq_sel = 1'b1; #1;
        chk("R1", "irq all mode", irq, 1);
        irq_sel = 1'b0;
    endtask

    task automatic t_single_latency();
        do_reset();
        write_one(8'hA5);
        chk("R4", "buf_empty after write", buf_empty, 0);
        chk("R5", "tx_valid edge1", tx_valid, 0);
        step();
        chk("R4", "buf_empty after move", buf_empty, 1);
        chk("R5", "tx_valid edge2", tx_valid, 0);
        step();
        chk("R5", "tx_valid edge3", tx_valid, 0);
        step();
        chk("R5", "tx_valid edge4", tx_valid, 1);
        chk("R5", "tx_byte", tx_byte, 8'hA5);
        step();
        step();
        chk("R8", "held without take", tx_valid, 1);
        chk("R8", "held byte", tx_byte, 8'hA5);
        tx_take = 1'b1;
        step();
        tx_take = 1'b0;
        chk("R8", "removed after take", tx_valid, 0);
    endtask

    task automatic t_order_overflow();
        logic [7:0] seq [4] = '{8'h11, 8'h22, 8'h33, 8'h44};
        do_reset();
        for (int k = 0; k < 4; k++) begin
            wr_en = 1'b1; wr_byte = seq[k];
            step();
        end
        wr_en = 1'b0;
        step();
        chk("R3", "no overflow when four held", overflow, 0);
        chk("R4", "buf_empty full", buf_empty, 0);
        chk("R6", "irq entry mode while full", irq, 0);
        write_one(8'h55);
        chk("R3", "overflow set", overflow, 1);
        for (int k = 0; k < 4; k++) begin
            chk("R2", "valid in order", tx_valid, 1);
            chk("R2", "byte in order", tx_byte, seq[k]);
            tx_take = 1'b1;
            step();
        end
        tx_take = 1'b0;
        chk("R3", "dropped byte absent", tx_valid, 0);
        step(); step(); step(); step();
        chk("R3", "dropped byte never appears", tx_valid, 0);
        chk("R3", "overflow sticky", overflow, 1);
    endtask

    task automatic t_full_write_take();
        logic [7:0] exp [4] = '{8'hA2, 8'hA3, 8'hA4, 8'hB5};
        do_reset();
        for (int k = 1; k <= 4; k++) begin
            wr_en = 1'b1; wr_byte = 8'hA0 + 8'(k);
            step();
        end
        wr_en = 1'b0;
        step();
        chk("R9", "head before", tx_byte, 8'hA1);
        wr_en = 1'b1; wr_byte = 8'hB5; tx_take = 1'b1;
        step();
        wr_en = 1'b0; tx_take = 1'b0;
        chk("R9", "no overflow", overflow, 0);
        for (int k = 0; k < 4; k++) begin
            chk("R9", "byte after shift", tx_byte, exp[k]);
            tx_take = 1'b1;
            step();
        end
        tx_take = 1'b0;
        chk("R9", "empty after drain", tx_valid, 0);
    endtask

    task automatic t_trigger_modes();
        do_reset();
        irq_sel = 1'b1; dma_sel = 1'b0; #1;
        chk("R6", "irq all-empty idle", irq, 1);
        chk("R7", "dma entry idle", dma_req, 1);
        wr_en = 1'b1; wr_byte = 8'h3C; #1;
        chk("R7", "dma drops in write cycle", dma_req, 0);
        step();
        wr_en = 1'b0; #1;
        chk("R6", "irq all mode one byte", irq, 0);
        chk("R7", "dma entry occupied", dma_req, 0);
        step();
        chk("R7", "dma entry freed", dma_req, 1);
        chk("R6", "irq all mode still held", irq, 0);
        irq_sel = 1'b0; dma_sel = 1'b1; #1;
        chk("R6", "irq entry mode", irq, 1);
        chk("R7", "dma all mode held", dma_req, 0);
        step(); step();
        chk("R5", "byte at exit", tx_valid, 1);
        tx_take = 1'b1;
        step();
        tx_take = 1'b0;
        chk("R7", "dma all mode drained", dma_req, 1);
        wr_en = 1'b1; wr_byte = 8'h77; #1;
        chk("R7", "dma all mode write cycle", dma_req, 0);
        step();
        wr_en = 1'b0;
    endtask

    initial begin
        rst = 1'b1; wr_en = 1'b0; wr_byte = '0; tx_take = 1'b0;
        irq_sel = 1'b0; dma_sel = 1'b0;
        fork
            begin
                t_reset_state();
                t_single_latency();
                t_order_overflow();
                t_full_write_take();
                t_trigger_modes();
            end
            begin
                repeat (20000) @(posedge clk);
                n_checks++;
                n_errors++;
                $display("FAIL watchdog: actual=expired expected=done");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule